// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block generates one pulse-width-modulated output per channel, with every timing value counted in cycles of its input clock. A processor programs each channel through a private 0x20-byte window on a simple bus. Writes take effect on the clock edge where they are presented. Reads are combinational and return in the same cycle. Each window holds a period, a high time, a burst length and a control word. The control word carries enable, output inversion and a run-forever flag.

Timing values written to a channel are shadowed. The waveform keeps running on the values it already has until software writes the control word with enable set. That write loads the shadow values into the channel's counter and starts a fresh period at count zero. A channel can run forever, or it can emit a set number of periods and then switch itself off.

Top module: `pwm_bank`

## Requirements
- R1: Channel c owns byte addresses c*0x20 to c*0x20+0x1F. Inside the window, byte offset 0x0 holds the period, 0x4 the high time, 0x8 the burst length and 0xC the control word. Every one of these reads back exactly what was last written. Offsets 0x10 to 0x1C read zero and ignore writes. An access whose two low address bits are not zero also reads zero and ignores writes.
- R2: In the control word, bit 0 is enable, bit 1 is invert and bit 2 is keep. All higher bits read zero.
- R3: Take an enabled channel with invert 0, committed period P and high time H. From the cycle after the commit write, its counter runs 0,1,…,P-1 and then repeats. The output is 1 while the count is below H and 0 otherwise. A period of 0 behaves as a period of 1.
- R4: A high time of 0 holds the output at 0 for the whole period. A high time of P or more holds it at 1 for the whole period.
- R5: Invert set to 1 complements the output at all times. An inverted channel therefore idles at 1 when it is disabled.
- R6: Writes to the period, high-time or burst words do not change a running waveform. Writing the control word with bit 0 set loads them and restarts the counter at zero on the next cycle.
- R7: With keep 0, the channel emits exactly N periods, where N is the committed burst length and a value of 0 counts as 1. It then clears its own enable bit, and its output returns to the idle level.
- R8: Writing the control word with enable 0 drives the output to the idle level from the next cycle and holds the counter at zero. Enabling the channel again starts a fresh period at count zero.
- R9: After reset every register reads zero, and every output is 0.
- R10: Channels are independent. Each one keeps its own phase, timing and mode while the others run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte address; ADDR_W = log2(NUM_CH)+5 |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| pwmOut | output | NUM_CH | One modulated output per channel |

## Verification
Assertions check the following on every cycle:
- a disabled channel holds its counter at zero;
- the counter stays inside the committed period;
- the active timing values change only on a commit, after which the count is zero;
- a finished burst clears enable unless a control write arrives in the same cycle.

Only the bench scenarios can show the waveform itself: the high/low shape across swept periods and high times, the restart point after a commit, the exact number of burst periods, the inverted idle level and phase independence between channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int BUS_W = 32;
  localparam int WIN_SHIFT = 5;
  localparam logic [2:0] WORD_PERIOD = 3'd0;
  localparam logic [2:0] WORD_HIGH   = 3'd1;
  localparam logic [2:0] WORD_BURST  = 3'd2;
  localparam logic [2:0] WORD_CTRL   = 3'd3;

  typedef struct packed {
    logic commit;
    logic run;
    logic keep;
    logic invert;
  } chanCtl_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 32,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + WIN_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [NUM_CH-1:0] doneIn,
  output chanCtl_t          ctlOut [NUM_CH],
  output logic [CNT_W-1:0]  shPeriod [NUM_CH],
  output logic [CNT_W-1:0]  shHigh [NUM_CH],
  output logic [CNT_W-1:0]  shBurst [NUM_CH]
);
  logic [CH_W-1:0] chSel;
  logic [2:0] wordSel;
  logic alignOk;
  logic [NUM_CH-1:0] enR, invR, keepR, ctrlHit;
  logic [CNT_W-1:0] periodR [NUM_CH];
  logic [CNT_W-1:0] highR [NUM_CH];
  logic [CNT_W-1:0] burstR [NUM_CH];

  assign chSel   = busAddr[ADDR_W-1:WIN_SHIFT];
  assign wordSel = busAddr[4:2];
  assign alignOk = (busAddr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR <= '0;
      invR <= '0;
      keepR <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        periodR[i] <= '0;
        highR[i] <= '0;
        burstR[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (busWrEn && alignOk && chSel == CH_W'(i)) begin
          if (wordSel == WORD_PERIOD) periodR[i] <= busWdata[CNT_W-1:0];
          if (wordSel == WORD_HIGH)   highR[i]   <= busWdata[CNT_W-1:0];
          if (wordSel == WORD_BURST)  burstR[i]  <= busWdata[CNT_W-1:0];
        end
        if (ctrlHit[i]) begin
          enR[i]   <= busWdata[0];
          invR[i]  <= busWdata[1];
          keepR[i] <= busWdata[2];
        end else if (doneIn[i]) begin
          enR[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
    assign ctrlHit[c] = busWrEn && alignOk && chSel == CH_W'(c) && wordSel == WORD_CTRL;
    assign ctlOut[c].commit = ctrlHit[c] && busWdata[0];
    assign ctlOut[c].run    = enR[c];
    assign ctlOut[c].keep   = keepR[c];
    assign ctlOut[c].invert = invR[c];
    assign shPeriod[c] = periodR[c];
    assign shHigh[c]   = highR[c];
    assign shBurst[c]  = burstR[c];

    AST_DONE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
      (doneIn[c] && !ctrlHit[c]) |=> !enR[c]); // R7
  end

  always_comb begin
    busRdata = '0;
    if (alignOk) begin
      unique case (wordSel)
        WORD_PERIOD: busRdata = BUS_W'(periodR[chSel]);
        WORD_HIGH:   busRdata = BUS_W'(highR[chSel]);
        WORD_BURST:  busRdata = BUS_W'(burstR[chSel]);
        WORD_CTRL:   busRdata = BUS_W'({keepR[chSel], invR[chSel], enR[chSel]});
        default:     busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCtl_t         ctl,
  input  logic [CNT_W-1:0] shPeriod,
  input  logic [CNT_W-1:0] shHigh,
  input  logic [CNT_W-1:0] shBurst,
  output logic             pwmOut,
  output logic             doneOut
);
  logic [CNT_W-1:0] cnt, actPeriod, actHigh, left;
  logic lastTick;

  assign lastTick = ({1'b0, cnt} + 1'b1) >= {1'b0, actPeriod};
  assign doneOut  = ctl.run && lastTick && !ctl.keep && (left <= CNT_W'(1));
  assign pwmOut   = ctl.invert ^ (ctl.run && (cnt < actHigh));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      actPeriod <= '0;
      actHigh <= '0;
      left <= '0;
    end else if (ctl.commit) begin
      cnt <= '0;
      actPeriod <= shPeriod;
      actHigh <= shHigh;
      left <= shBurst;
    end else if (!ctl.run) begin
      cnt <= '0;
    end else if (lastTick) begin
      cnt <= '0;
      if (!ctl.keep && left > CNT_W'(1)) left <= left - 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> cnt == '0); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) || (cnt < actPeriod)); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(actPeriod) && $stable(actHigh))); // R6
  AST_COMMIT_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> cnt == '0); // R6
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 32,
  localparam int ADDR_W = $clog2(NUM_CH) + WIN_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCtl_t ctl [NUM_CH];
  logic [CNT_W-1:0] shPeriod [NUM_CH];
  logic [CNT_W-1:0] shHigh [NUM_CH];
  logic [CNT_W-1:0] shBurst [NUM_CH];
  logic [NUM_CH-1:0] done;

  initial begin
    assert (NUM_CH == 2 || NUM_CH == 4 || NUM_CH == 8);
    assert (CNT_W >= 2 && CNT_W <= BUS_W);
  end

  pwm_bank_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .doneIn(done),
    .ctlOut(ctl), .shPeriod(shPeriod), .shHigh(shHigh), .shBurst(shBurst)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_chan #(.CNT_W(CNT_W)) i_chan (
      .clk(clk), .rstN(rstN), .ctl(ctl[c]), .shPeriod(shPeriod[c]),
      .shHigh(shHigh[c]), .shBurst(shBurst[c]), .pwmOut(pwmOut[c]),
      .doneOut(done[c])
    );
  end
endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int NCH = 4;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] pwmOut;
  int cyc = 0;
  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank #(.NUM_CH(NCH), .CNT_W(32)) i_pwm_bank (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1;
    busAddr = AW'(ch * 32 + off);
    busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    busAddr = AW'(ch * 32 + off);
    #1 d = busRdata;
  endtask

  function automatic logic expOut(input int k, input int p, input int h, input logic inv);
    int pe;
    pe = (p == 0) ? 1 : p;
    return ((k % pe) < h) ^ inv;
  endfunction

  // program, commit, return at the sample point of count zero
  task automatic start(input int ch, input int p, input int h, input int b,
                       input logic [31:0] ctrl, output int t0);
    wr(ch, 'h0, p);
    wr(ch, 'h4, h);
    wr(ch, 'h8, b);
    wr(ch, 'hC, ctrl);
    t0 = cyc;
  endtask

  initial begin
    logic [31:0] d;
    int t0, t1, pe;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 16; o += 4) begin
        rd(c, o, d);
        check("R9 reg after reset", d, 0);
      end
    check("R9 outputs after reset", pwmOut, 0);
    rstN = 1'b1;

    // R1 / R2 readback over all channels, unused and misaligned offsets
    for (int c = 0; c < NCH; c++) begin
      wr(c, 'h0, 32'hA000_0000 + c);
      wr(c, 'h4, 32'h0B00_0010 + c);
      wr(c, 'h8, 32'h00C0_0020 + c);
      wr(c, 'hC, 32'hFFFF_FFFE);
      wr(c, 'h10, 32'h1234_5678);
      wr(c, 'h1, 32'h5555_5555);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c, 'h0, d); check("R1 period readback", d, 32'hA000_0000 + c);
      rd(c, 'h4, d); check("R1 high readback", d, 32'h0B00_0010 + c);
      rd(c, 'h8, d); check("R1 burst readback", d, 32'h00C0_0020 + c);
      rd(c, 'hC, d); check("R2 ctrl readback bits", d, 32'h6);
      rd(c, 'h10, d); check("R1 unused offset", d, 0);
      rd(c, 'h1, d); check("R1 misaligned read", d, 0);
      wr(c, 'hC, 0);
    end

    // R3 / R4 sweep, normal polarity, channel 0
    for (int p = 0; p <= 6; p++)
      for (int h = 0; h <= 7; h++) begin
        start(0, p, h, 0, 32'h5, t0);
        pe = (p == 0) ? 1 : p;
        for (int k = 0; k < 2 * pe + 2; k++) begin
          check((h == 0 || h >= pe) ? "R4 flat level" : "R3 waveform",
                pwmOut[0], expOut(cyc - t0, p, h, 1'b0));
          @(negedge clk);
        end
      end
    wr(0, 'hC, 0);

    // R5 inverted sweep on channel 2 and inverted idle level
    for (int p = 1; p <= 4; p++)
      for (int h = 0; h <= 5; h++) begin
        start(2, p, h, 0, 32'h7, t0);
        for (int k = 0; k < 2 * p + 1; k++) begin
          check("R5 inverted waveform", pwmOut[2], expOut(cyc - t0, p, h, 1'b1));
          @(negedge clk);
        end
      end
    wr(2, 'hC, 32'h6);
    check("R5 inverted idle", pwmOut[2], 1);
    check("R8 disabled idle after write", pwmOut[2], 1);

    // R6 shadow: new timing ignored until enable rewritten
    start(1, 4, 1, 0, 32'h5, t0);
    wr(1, 'h0, 9);
    wr(1, 'h4, 7);
    for (int k = 0; k < 10; k++) begin
      check("R6 old waveform kept", pwmOut[1], expOut(cyc - t0, 4, 1, 1'b0));
      @(negedge clk);
    end
    wr(1, 'hC, 32'h5);
    t0 = cyc;
    for (int k = 0; k < 20; k++) begin
      check("R6 committed waveform", pwmOut[1], expOut(cyc - t0, 9, 7, 1'b0));
      @(negedge clk);
    end

    // R8 disable mid-run, then fresh restart
    start(1, 5, 3, 0, 32'h5, t0);
    repeat (3) @(negedge clk);
    wr(1, 'hC, 32'h4);
    for (int k = 0; k < 6; k++) begin
      check("R8 disabled output", pwmOut[1], 0);
      @(negedge clk);
    end
    wr(1, 'hC, 32'h5);
    t0 = cyc;
    for (int k = 0; k < 10; k++) begin
      check("R8 fresh restart", pwmOut[1], expOut(cyc - t0, 5, 3, 1'b0));
      @(negedge clk);
    end
    wr(1, 'hC, 0);

    // R7 counted bursts: N=3 and N=0 (acts as 1)
    start(3, 4, 2, 3, 32'h1, t0);
    for (int k = 0; k < 12; k++) begin
      check("R7 burst waveform", pwmOut[3], expOut(k, 4, 2, 1'b0));
      @(negedge clk);
    end
    for (int k = 0; k < 5; k++) begin
      check("R7 burst ended output", pwmOut[3], 0);
      @(negedge clk);
    end
    rd(3, 'hC, d);
    check("R7 enable self-cleared", d, 0);
    start(3, 3, 1, 0, 32'h3, t0);
    for (int k = 0; k < 3; k++) begin
      check("R7 zero burst single period", pwmOut[3], expOut(k, 3, 1, 1'b1));
      @(negedge clk);
    end
    check("R7 zero burst ends inverted idle", pwmOut[3], 1);
    rd(3, 'hC, d);
    check("R7 zero burst enable cleared", d, 32'h2);

    // R10 two channels with different phase and polarity
    start(0, 5, 2, 0, 32'h5, t0);
    repeat (2) @(negedge clk);
    start(1, 3, 1, 0, 32'h7, t1);
    for (int k = 0; k < 15; k++) begin
      check("R10 channel 0", pwmOut[0], expOut(cyc - t0, 5, 2, 1'b0));
      check("R10 channel 1", pwmOut[1], expOut(cyc - t1, 3, 1, 1'b1));
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule